// File: doc/BRIEF.md
# Two-Level Aperture Address Translator

This block turns bus addresses that land inside a graphics aperture window into physical memory addresses. A lookup first consults an on-chip directory of table-page pointers, then fetches one 32-bit entry from a second-level table page in system memory. A small fully associative cache of recent translations lets repeated accesses to the same 4 KB page skip the memory fetch.

Software sets the block up through three write strobes. One loads or removes a single directory slot from a packed word. One selects the window size from a size code. One writes a control word, and a specific two-write sequence on that word invalidates the translation cache. Translations are requested with a valid/ready handshake. Each result comes back as a one-cycle response that carries the physical address, a fault flag and an out-of-window flag.

The aperture base is a parameter aligned to the largest window. The offset of a request is its address minus that base. Directory slot = offset[27:22]. Second-level index = offset[21:12]. The page offset, bits 11:0, passes through unchanged.

Top module: `aperture_xlat`

## Requirements
- R1: After reset:
  - every directory slot is absent;
  - the window is 256 MB;
  - `req_ready` is 1;
  - `rsp_valid` and `mem_req` are 0.
- R2: A directory load word is decoded as follows:
  - bits 31:12 give the table-page address;
  - bit 8 is the present flag;
  - bits 5:0 pick the slot;
  - bits 11:9 and 7:6 have no effect on any translation.
- R3: A load word with bit 8 clear removes the addressed slot. Later lookups through that slot then fault.
- R4: A walk issues exactly one `mem_req` pulse, at address table page + 4 × (offset[21:12]). Only one read is outstanding at any time, and `req_ready` stays 0 until the read returns.
- R5: A second-level entry with bit 0 set gives `rsp_addr` = {entry[31:12], request[11:0]}. An entry with bit 0 clear gives `rsp_fault`=1 and `rsp_addr`=0.
- R6: Size codes map to windows as follows:
  - 0 selects 256 MB;
  - 32 selects 128 MB;
  - 48 selects 64 MB;
  - 56 selects 32 MB.
  Any other code leaves the current window unchanged.
- R7: When the offset is at or beyond the window size, the request address is returned unchanged with `rsp_outwin`=1 and `rsp_fault`=0. No memory read is issued, and the response arrives one cycle after acceptance.
- R8: When an in-window lookup finds its slot absent and the cache misses, the block faults one cycle after acceptance without any memory read.
- R9: The cache holds 4 page translations and fills only from valid entries. A hit responds one cycle after acceptance without a read. When all four ways are in use, a new fill replaces them in round-robin order starting from way 0 after each invalidation, so the oldest fill since the last invalidation goes first.
- R10: A control write of 0x2280 whose previous control write was 0x2200 invalidates the whole cache. Any other control write, including 0x2280 after a different value, leaves the cache unchanged.
- R11: Any directory load word invalidates the whole cache.
- R12: Responses appear one cycle after acceptance for the out-of-window, hit and absent-slot cases. For a walk, the response appears one cycle after `mem_rvalid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_we | input | 1 | Directory load strobe |
| dir_wdata | input | 32 | Packed directory load word |
| size_we | input | 1 | Size code write strobe |
| size_code | input | 8 | Window size code |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_addr | output | 32 | Translated or passed-through address |
| rsp_fault | output | 1 | Translation absent or invalid |
| rsp_outwin | output | 1 | Address outside the window |
| mem_req | output | 1 | Second-level read pulse |
| mem_addr | output | 32 | Second-level entry address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Second-level entry |

## Verification
Some properties are checked by assertions on every cycle:
- a single outstanding read, with the request side stalled while it is pending;
- one-cycle read pulses;
- passthrough of out-of-window addresses;
- the zero address on faults;
- every response traced back to an acceptance or to returned read data.

Other behaviour needs the bench's reference model across scenarios:
- cache hits after a walk, and round-robin eviction order;
- the flush sequence and its near-miss variants;
- the window bounds under each size code, and invalid codes being ignored;
- slot removal and the read address arithmetic.

// File: rtl/apx_pkg.sv
package apx_pkg;

   typedef enum logic [1:0] {
      WIN_FULL   = 2'd0,
      WIN_HALF   = 2'd1,
      WIN_QUART  = 2'd2,
      WIN_EIGHTH = 2'd3
   } win_sel_e;

   typedef struct packed {
      logic     ok;
      win_sel_e sel;
   } size_dec_t;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } walk_st_e;

   localparam logic [15:0] CTL_ARM = 16'h2200;
   localparam logic [15:0] CTL_RUN = 16'h2280;

   function automatic size_dec_t decode_size(input logic [7:0] code);
      size_dec_t d;
      d.ok  = 1'b1;
      d.sel = WIN_FULL;
      case (code)
         8'd0:    d.sel = WIN_FULL;
         8'd32:   d.sel = WIN_HALF;
         8'd48:   d.sel = WIN_QUART;
         8'd56:   d.sel = WIN_EIGHTH;
         default: d.ok  = 1'b0;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/apx_ctl.sv
module apx_ctl
   import apx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        size_we,
   input  logic [7:0]  size_code,
   input  logic        ctl_we,
   input  logic [15:0] ctl_wdata,
   output win_sel_e    win_sel,
   output logic        flush
);
   logic [15:0] last_ctl;
   size_dec_t   dec;

   assign dec   = decode_size(size_code);
   assign flush = ctl_we && (ctl_wdata == CTL_RUN) && (last_ctl == CTL_ARM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_sel  <= WIN_FULL;
         last_ctl <= CTL_RUN;
      end else begin
         if (size_we && dec.ok) win_sel <= dec.sel;
         if (ctl_we) last_ctl <= ctl_wdata;
      end
   end
endmodule

// File: rtl/apx_dir.sv
module apx_dir #(
   parameter int SLOTS  = 64,
   parameter int SLOT_W = 6,
   parameter int PPN_W  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic              wr_present,
   input  logic [PPN_W-1:0]  wr_ppn,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic              rd_present,
   output logic [PPN_W-1:0]  rd_ppn
);
   logic             present_q [SLOTS];
   logic [PPN_W-1:0] ppn_q     [SLOTS];

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            present_q[g] <= 1'b0;
            ppn_q[g]     <= '0;
         end else if (we && (wr_slot == SLOT_W'(g))) begin
            present_q[g] <= wr_present;
            ppn_q[g]     <= wr_ppn;
         end
      end
   end

   assign rd_present = present_q[rd_slot];
   assign rd_ppn     = ppn_q[rd_slot];
endmodule

// File: rtl/apx_tcache.sv
module apx_tcache #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 16,
   parameter int PPN_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [TAG_W-1:0] look_tag,
   output logic             hit,
   output logic [PPN_W-1:0] hit_ppn,
   input  logic             fill,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic [PPN_W-1:0] fill_ppn
);
   localparam int PTR_W = (WAYS > 1) ? $clog2(WAYS) : 1;

   logic [WAYS-1:0]  vld_q;
   logic [WAYS-1:0]  match;
   logic [TAG_W-1:0] tag_q [WAYS];
   logic [PPN_W-1:0] ppn_q [WAYS];
   logic [PTR_W-1:0] rr_q;

   for (genvar g = 0; g < WAYS; g++) begin : g_way
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[g] <= 1'b0;
            tag_q[g] <= '0;
            ppn_q[g] <= '0;
         end else if (flush) begin
            vld_q[g] <= 1'b0;
         end else if (fill && (rr_q == PTR_W'(g))) begin
            vld_q[g] <= 1'b1;
            tag_q[g] <= fill_tag;
            ppn_q[g] <= fill_ppn;
         end
      end
      assign match[g] = vld_q[g] && (tag_q[g] == look_tag);
   end

   always_comb begin
      hit_ppn = '0;
      for (int i = 0; i < WAYS; i++) begin
         if (match[i]) hit_ppn = hit_ppn | ppn_q[i];
      end
   end
   assign hit = |match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rr_q <= '0;
      else if (flush) rr_q <= '0;
      else if (fill)  rr_q <= (rr_q == PTR_W'(WAYS - 1)) ? '0 : rr_q + 1'b1;
   end
endmodule

// File: rtl/aperture_xlat.sv
module aperture_xlat
   import apx_pkg::*;
#(
   parameter int          AW         = 32,
   parameter int          SLOTS      = 64,
   parameter int          L2_ENTRIES = 1024,
   parameter int          WAYS       = 4,
   parameter logic [31:0] APER_BASE  = 32'h8000_0000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dir_we,
   input  logic [31:0]   dir_wdata,
   input  logic          size_we,
   input  logic [7:0]    size_code,
   input  logic          ctl_we,
   input  logic [15:0]   ctl_wdata,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_addr,
   output logic          rsp_valid,
   output logic [AW-1:0] rsp_addr,
   output logic          rsp_fault,
   output logic          rsp_outwin,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_rvalid,
   input  logic [31:0]   mem_rdata
);
   localparam int PG     = 12;
   localparam int L2_W   = $clog2(L2_ENTRIES);
   localparam int SLOT_W = $clog2(SLOTS);
   localparam int SPAN_W = PG + L2_W + SLOT_W;
   localparam int TAG_W  = SPAN_W - PG;
   localparam int PPN_W  = AW - PG;
   localparam int PRES_B = 8;

   walk_st_e         st_q;
   win_sel_e         win_sel;
   logic             flush_ctl, flush_any, kill_q;
   logic [AW-1:0]    off;
   logic             in_win, accept, hit, slot_present, fill;
   logic [TAG_W-1:0] tag, hold_tag_q;
   logic [SLOT_W-1:0] slot;
   logic [L2_W-1:0]  l2_idx;
   logic [PPN_W-1:0] hit_ppn, slot_ppn;
   logic [PG-1:0]    hold_lo_q;
   logic             field_unused;

   assign field_unused = ^{dir_wdata[PG-1:PRES_B+1], dir_wdata[PRES_B-1:SLOT_W],
                           mem_rdata[PG-1:1]};

   assign off    = req_addr - AW'(APER_BASE);
   assign in_win = (off >> (SPAN_W - int'(win_sel))) == '0;
   assign tag    = off[SPAN_W-1:PG];
   assign slot   = off[SPAN_W-1:PG+L2_W];
   assign l2_idx = off[PG+L2_W-1:PG];

   assign req_ready = (st_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign flush_any = flush_ctl || dir_we;
   assign fill      = (st_q == ST_WAIT) && mem_rvalid && mem_rdata[0] && !kill_q && !flush_any;

   apx_ctl u_ctl (
      .clk, .rst_n, .size_we, .size_code, .ctl_we, .ctl_wdata,
      .win_sel (win_sel),
      .flush   (flush_ctl)
   );

   apx_dir #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .PPN_W(PPN_W)) u_dir (
      .clk, .rst_n,
      .we         (dir_we),
      .wr_slot    (dir_wdata[SLOT_W-1:0]),
      .wr_present (dir_wdata[PRES_B]),
      .wr_ppn     (dir_wdata[AW-1:PG]),
      .rd_slot    (slot),
      .rd_present (slot_present),
      .rd_ppn     (slot_ppn)
   );

   apx_tcache #(.WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_cache (
      .clk, .rst_n,
      .flush    (flush_any),
      .look_tag (tag),
      .hit      (hit),
      .hit_ppn  (hit_ppn),
      .fill     (fill),
      .fill_tag (hold_tag_q),
      .fill_ppn (mem_rdata[AW-1:PG])
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         kill_q     <= 1'b0;
         hold_tag_q <= '0;
         hold_lo_q  <= '0;
         rsp_valid  <= 1'b0;
         rsp_addr   <= '0;
         rsp_fault  <= 1'b0;
         rsp_outwin <= 1'b0;
         mem_req    <= 1'b0;
         mem_addr   <= '0;
      end else begin
         rsp_valid <= 1'b0;
         mem_req   <= 1'b0;
         kill_q    <= (st_q == ST_IDLE) ? flush_any : (kill_q || flush_any);
         case (st_q)
            ST_IDLE: if (accept) begin
               if (!in_win) begin
                  rsp_valid  <= 1'b1;
                  rsp_addr   <= req_addr;
                  rsp_fault  <= 1'b0;
                  rsp_outwin <= 1'b1;
               end else if (hit) begin
                  rsp_valid  <= 1'b1;
                  rsp_addr   <= {hit_ppn, req_addr[PG-1:0]};
                  rsp_fault  <= 1'b0;
                  rsp_outwin <= 1'b0;
               end else if (!slot_present) begin
                  rsp_valid  <= 1'b1;
                  rsp_addr   <= '0;
                  rsp_fault  <= 1'b1;
                  rsp_outwin <= 1'b0;
               end else begin
                  st_q       <= ST_WAIT;
                  mem_req    <= 1'b1;
                  mem_addr   <= {slot_ppn, {PG{1'b0}}} + AW'({l2_idx, 2'b00});
                  hold_tag_q <= tag;
                  hold_lo_q  <= req_addr[PG-1:0];
               end
            end
            ST_WAIT: if (mem_rvalid) begin
               st_q       <= ST_IDLE;
               rsp_valid  <= 1'b1;
               rsp_outwin <= 1'b0;
               rsp_fault  <= !mem_rdata[0];
               rsp_addr   <= mem_rdata[0] ? {mem_rdata[AW-1:PG], hold_lo_q} : '0;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/apx_chk.sv
module apx_chk #(
   parameter int AW         = 32,
   parameter int SLOTS      = 64,
   parameter int L2_ENTRIES = 1024,
   parameter int WAYS       = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic [AW-1:0] req_addr,
   input logic          rsp_valid,
   input logic [AW-1:0] rsp_addr,
   input logic          rsp_fault,
   input logic          rsp_outwin,
   input logic          mem_req,
   input logic          mem_rvalid
);
   logic busy_q;

   initial begin
      a_cfg_geometry: assert ($clog2(SLOTS) <= 6 && (1 << $clog2(SLOTS)) == SLOTS &&
                              L2_ENTRIES * 4 <= 4096 && WAYS >= 1 &&
                              12 + $clog2(L2_ENTRIES) + $clog2(SLOTS) < AW)
         else $error("aperture_xlat geometry parameters out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          busy_q <= 1'b0;
      else if (mem_rvalid) busy_q <= 1'b0;
      else if (mem_req)    busy_q <= 1'b1;
   end

   a_r4_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !busy_q);

   a_r4_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req || busy_q) |-> !req_ready);

   a_r4_mem_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   a_r7_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_outwin) |-> ($past(req_valid && req_ready) &&
                                     rsp_addr == $past(req_addr) && !rsp_fault));

   a_r5_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_addr == '0 && !rsp_outwin));

   a_r12_cause: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($past(req_valid && req_ready) || $past(busy_q && mem_rvalid)));
endmodule

bind aperture_xlat apx_chk #(
   .AW(AW), .SLOTS(SLOTS), .L2_ENTRIES(L2_ENTRIES), .WAYS(WAYS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_addr   (req_addr),
   .rsp_valid  (rsp_valid),
   .rsp_addr   (rsp_addr),
   .rsp_fault  (rsp_fault),
   .rsp_outwin (rsp_outwin),
   .mem_req    (mem_req),
   .mem_rvalid (mem_rvalid)
);

// File: tb/sim_aperture_xlat.sv
`timescale 1ns/1ps
module sim_aperture_xlat;
   localparam logic [31:0] BASE = 32'h8000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dir_we = 1'b0;
   logic [31:0] dir_wdata = '0;
   logic        size_we = 1'b0;
   logic [7:0]  size_code = '0;
   logic        ctl_we = 1'b0;
   logic [15:0] ctl_wdata = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic        rsp_valid, rsp_fault, rsp_outwin, mem_req;
   logic [31:0] rsp_addr, mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   aperture_xlat u0 (
      .clk, .rst_n, .dir_we, .dir_wdata, .size_we, .size_code, .ctl_we, .ctl_wdata,
      .req_valid, .req_ready, .req_addr, .rsp_valid, .rsp_addr, .rsp_fault,
      .rsp_outwin, .mem_req, .mem_addr, .mem_rvalid, .mem_rdata
   );

   // ---- reference state ----
   bit [31:0] img [bit [31:0]];
   bit [19:0] m_ppn [64];
   bit        m_pres [64];
   int        m_shrink = 0;
   bit [15:0] m_last = 16'h2280;
   int        cq_tag [$];
   bit [19:0] cq_ppn [$];

   // ---- memory responder, fixed latency ----
   int        lat = 0;
   bit [31:0] lat_addr;
   always @(negedge clk) begin
      if (lat > 0) begin
         lat = lat - 1;
         if (lat == 0) begin
            mem_rvalid = 1'b1;
            mem_rdata  = img.exists(lat_addr) ? img[lat_addr] : 32'h0;
         end
      end else begin
         mem_rvalid = 1'b0;
      end
      if (mem_req) begin
         lat = 2;
         lat_addr = mem_addr;
      end
   end

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic dir_load(input bit [31:0] w);
      @(negedge clk); dir_we = 1'b1; dir_wdata = w;
      @(negedge clk); dir_we = 1'b0;
      m_pres[w[5:0]] = w[8];
      m_ppn[w[5:0]]  = w[31:12];
      cq_tag.delete(); cq_ppn.delete();
   endtask

   task automatic set_size(input bit [7:0] c);
      @(negedge clk); size_we = 1'b1; size_code = c;
      @(negedge clk); size_we = 1'b0;
      case (c)
         8'd0:  m_shrink = 0;
         8'd32: m_shrink = 1;
         8'd48: m_shrink = 2;
         8'd56: m_shrink = 3;
         default: ;
      endcase
   endtask

   task automatic ctl_write(input bit [15:0] d);
      @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
      @(negedge clk); ctl_we = 1'b0;
      if (d == 16'h2280 && m_last == 16'h2200) begin
         cq_tag.delete(); cq_ppn.delete();
      end
      m_last = d;
   endtask

   task automatic xlat(input bit [31:0] a, input string rq);
      bit [31:0] off, e_addr, e_maddr, e, got_maddr;
      bit        e_walk, e_fault, e_out;
      int        n, nm, s;
      int        qi [$];
      off = a - BASE;
      e_walk = 0; e_fault = 0; e_out = 0; e_addr = 0; e_maddr = 0;
      if ((off >> (28 - m_shrink)) != 0) begin
         e_out = 1; e_addr = a;
      end else begin
         qi = cq_tag.find_first_index(x) with (x == int'(off[27:12]));
         s  = int'(off[27:22]);
         if (qi.size() > 0) begin
            e_addr = {cq_ppn[qi[0]], a[11:0]};
         end else if (!m_pres[s]) begin
            e_fault = 1;
         end else begin
            e_walk  = 1;
            e_maddr = {m_ppn[s], 12'h000} + off[21:12] * 4;
            e = img.exists(e_maddr) ? img[e_maddr] : 32'h0;
            if (e[0]) begin
               e_addr = {e[31:12], a[11:0]};
               if (cq_tag.size() == 4) begin
                  void'(cq_tag.pop_front()); void'(cq_ppn.pop_front());
               end
               cq_tag.push_back(int'(off[27:12])); cq_ppn.push_back(e[31:12]);
            end else begin
               e_fault = 1;
            end
         end
      end
      @(negedge clk); req_valid = 1'b1; req_addr = a;
      @(negedge clk); req_valid = 1'b0;
      n = 1; nm = 0; got_maddr = 0;
      forever begin
         if (mem_req) begin nm++; got_maddr = mem_addr; end
         if (rsp_valid || n >= 20) break;
         @(negedge clk); n++;
      end
      chk(rsp_valid && rsp_addr == e_addr, rq, "rsp_addr", rsp_addr, e_addr);
      chk(rsp_fault == e_fault && rsp_outwin == e_out, rq, "fault/outwin",
          {rsp_fault, rsp_outwin}, {e_fault, e_out});
      chk(nm == int'(e_walk), rq, "memory reads", nm, int'(e_walk));
      chk(n == (e_walk ? 4 : 1), rq, "response cycle", n, e_walk ? 4 : 1);
      if (e_walk) chk(got_maddr == e_maddr, rq, "mem_addr", got_maddr, e_maddr);
   endtask

   initial begin
      #(20ns * 150000);
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // table for slot 0 at 0x0010_0000, slot 3 at 0x0020_0000
      img[32'h0010_0014] = 32'h1234_5001;  // index 5
      img[32'h0010_0018] = 32'h0000_0000;  // index 6 unmapped
      img[32'h0010_001C] = 32'h0007_7001;  // index 7
      img[32'h0010_0020] = 32'h0008_8001;  // index 8
      img[32'h0010_0024] = 32'h0009_9001;  // index 9
      img[32'h0010_0028] = 32'h000A_A001;  // index 10
      img[32'h0010_002C] = 32'h5555_5FFE;  // index 11, bit0 clear
      img[32'h0020_0FFC] = 32'hABCD_E001;  // index 1023
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req === 1'b0, "R1",
          "reset outputs", {req_ready, rsp_valid, mem_req}, 3'b100);

      // R1/R8: nothing present after reset
      xlat(BASE + 32'h0000_5123, "R1 R8 absent slot");

      // R2: attribute and reserved bits set, present, slot 0
      dir_load(32'h0010_0000 | 32'hE00 | 32'h0C0 | 32'h100 | 32'd0);
      dir_load(32'h0020_0000 | 32'h100 | 32'd3);
      xlat(BASE + 32'h0000_5ABC, "R2 R4 R5 walk");
      xlat(BASE + 32'h0000_5001, "R9 hit");
      xlat(BASE + 32'h0000_6000, "R5 invalid entry");
      xlat(BASE + 32'h0000_B0F0, "R5 bit0 clear");
      xlat(BASE + (32'd3 << 22) + (32'h3FF << 12) + 32'h10, "R4 top index");

      // R7: outside the window
      xlat(BASE - 32'd4, "R7 below base");
      xlat(BASE + 32'h1000_0000, "R7 above 256MB");

      // R6: window sizes
      set_size(8'd56);
      xlat(BASE + (32'd3 << 22) + (32'h3FF << 12), "R6 32MB inside");
      xlat(BASE + 32'h0280_0000, "R6 32MB outside");
      set_size(8'd5);
      xlat(BASE + 32'h0280_0000, "R6 bad code ignored");
      set_size(8'd48);
      xlat(BASE + 32'h0280_0000, "R6 64MB inside R8");
      xlat(BASE + 32'h0400_0000, "R6 64MB outside");
      set_size(8'd32);
      xlat(BASE + 32'h0400_0000, "R6 128MB inside");
      xlat(BASE + 32'h0800_0000, "R6 128MB outside");
      set_size(8'd0);

      // R9: round-robin eviction from a clean cache
      ctl_write(16'h2200); ctl_write(16'h2280);
      xlat(BASE + 32'h0000_5000, "R9 fill a");
      xlat(BASE + 32'h0000_7000, "R9 fill b");
      xlat(BASE + 32'h0000_8000, "R9 fill c");
      xlat(BASE + 32'h0000_9000, "R9 fill d");
      xlat(BASE + 32'h0000_5000, "R9 hit a");
      xlat(BASE + 32'h0000_A000, "R9 evict a");
      xlat(BASE + 32'h0000_5000, "R9 refill a");
      xlat(BASE + 32'h0000_8000, "R9 hit c");
      xlat(BASE + 32'h0000_7000, "R9 evicted b");

      // R10: flush sequence and near misses
      ctl_write(16'h2280);
      xlat(BASE + 32'h0000_8000, "R10 lone run word");
      ctl_write(16'h2200); ctl_write(16'h1111); ctl_write(16'h2280);
      xlat(BASE + 32'h0000_8000, "R10 broken sequence");
      ctl_write(16'h2200); ctl_write(16'h2280);
      xlat(BASE + 32'h0000_8000, "R10 flushed");

      // R11: unrelated directory write invalidates
      xlat(BASE + 32'h0000_8000, "R11 warm");
      dir_load(32'h0030_0000 | 32'h100 | 32'd5);
      xlat(BASE + 32'h0000_8000, "R11 after dir write");

      // R3: remove slot 0
      dir_load(32'h0000_0000);
      xlat(BASE + 32'h0000_5000, "R3 removed slot");
      xlat(BASE + (32'd3 << 22) + (32'h3FF << 12), "R3 other slot kept");

      repeat (2) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule